// File: doc/BRIEF.md
# Auto-Scale Exponent Generator

This block keeps weak signals in a fixed-point channel emulator on enough bits. It picks power-of-two gains for the two ADC input streams and for the active coefficient set. It also tells each output path how to undo the total gain. Over each block of valid input samples it tracks the peak magnitude of both streams. From those peaks it derives one input-gain exponent, shared by the two external input amplifiers, and that exponent takes effect for the following block. A coefficient exponent is captured whenever a new channel profile is loaded, from the peak magnitude of that profile.

For each output, the block adds the coefficient exponent to the input exponent and subtracts the sliding-truncation exponent that the output normaliser reports for that output. The result is a signed 9-bit restore code for the external output amplifier. The exponent sum passes through a delay line matched to the filter latency, so each code lines up with the output data it describes. The block outputs digital codes only.

Top module: `asf_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `gain_exp`, `restore0` and `restore1` are all zero.
- R2: A channel whose block peak magnitude is at least one quarter of full scale (2048 for 14-bit samples) contributes exponent 0.
- R3: A channel whose block peak p is below one quarter of full scale contributes the largest k, capped at 8, for which 2^k·p stays below full scale (8192). Equivalently, 2^k·p lands in [4096, 8192). A peak of zero gives 8.
- R4: The shared input exponent is the minimum of the two channel exponents.
- R5: The peak of a channel is the largest |sample| over one block of 256 valid samples. Cycles with `in_valid` low do not affect the peak or the block count. The peak restarts from zero for each block. The most negative sample (-8192) counts as magnitude 8192.
- R6: `gain_exp` changes only on the clock edge that takes the last valid sample of a block. It then holds its value for the whole next block.
- R7: On a cycle with `coef_load` high, the coefficient exponent is captured from `coef_peak` (an unsigned fraction, 1.0 = 2^16). A value of at least one half (bit 15 set) gives 0. Otherwise the exponent is the largest k, capped at 8, for which 2^k·h stays below 1.0, and a zero peak gives 8. The exponent holds between loads.
- R8: The restore value for an output is v = kh + kx − s. Here kh + kx is the exponent sum present 4 cycles before the edge that registers the code, and s is that output's slide exponent present at that edge.
- R9: Code format: bit 8 set means divide by 2^|v| and is used when v > 0. Bit 8 clear means multiply by 2^|v| and is used when v ≤ 0. Bits 7:0 hold |v|.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input samples valid this cycle |
| adc0 | input | 14 | Signed sample, input stream 0 |
| adc1 | input | 14 | Signed sample, input stream 1 |
| coef_load | input | 1 | New channel profile strobe |
| coef_peak | input | 16 | Peak coefficient magnitude of the profile |
| slide0 | input | 5 | Sliding-truncation exponent, output 0 |
| slide1 | input | 5 | Sliding-truncation exponent, output 1 |
| gain_exp | output | 4 | Shared input-gain exponent (0..8) |
| restore0 | output | 9 | Restore code, output 0 |
| restore1 | output | 9 | Restore code, output 1 |

## Verification
The assertions assume that `coef_load` is only a strobe and that `coef_peak` need not be stable outside it. They also assume that the exponent sum never exceeds twice the cap, which holds only because both exponents are clamped at 8. The stimulus drives blocks that are full scale, exactly on the quarter threshold, just below it, all zero and most negative. It inserts invalid cycles that carry large values, loads profiles in the middle of a block, and changes the slide exponents so that the restore value takes positive, zero and negative values. Every cycle is compared against a queue-based reference model that works out its exponents by repeated doubling.

// File: rtl/asf_pkg.sv
package asf_pkg;
  localparam int CODE_W = 9;

  // signed restore value -> direction bit + magnitude
  function automatic logic [CODE_W-1:0] make_code(input int v);
    if (v > 0) return {1'b1, 8'(v)};
    else       return {1'b0, 8'(-v)};
  endfunction
endpackage

// File: rtl/asf_exp_calc.sv
// Power-of-two exponent that lifts a magnitude into the top octave below
// full scale (2^NB); zero unless mag < 2^(NB-THR); clamped to MAXE.
module asf_exp_calc #(
  parameter int NB    = 13,
  parameter int THR   = 2,
  parameter int MAXE  = 8,
  parameter int EXP_W = 4
) (
  input  logic [NB:0]      mag,
  output logic [EXP_W-1:0] k
);
  localparam logic [NB:0] LIMIT = (NB+1)'(1) << (NB - THR);

  int msb;
  int raw;

  always_comb begin
    msb = 0;
    for (int i = 0; i <= NB; i++)
      if (mag[i]) msb = i;
    raw = NB - 1 - msb;
    if (mag >= LIMIT)      k = '0;
    else if (mag == '0)    k = EXP_W'(MAXE);
    else if (raw > MAXE)   k = EXP_W'(MAXE);
    else                   k = EXP_W'(raw);
  end
endmodule

// File: rtl/asf_block_peak.sv
// Per-block peak tracking of two streams and the shared input exponent.
module asf_block_peak #(
  parameter int W     = 14,
  parameter int BLK   = 256,
  parameter int MAXE  = 8,
  parameter int EXP_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] x0,
  input  logic signed [W-1:0] x1,
  output logic [EXP_W-1:0]    gain
);
  localparam int CNT_W = (BLK > 1) ? $clog2(BLK) : 1;

  logic [W-1:0]     a0, a1, pk0, pk1, n0, n1;
  logic [CNT_W-1:0] cnt;
  logic [EXP_W-1:0] k0, k1, kmin;
  logic             last;

  assign a0   = x0[W-1] ? (~x0 + 1'b1) : x0;
  assign a1   = x1[W-1] ? (~x1 + 1'b1) : x1;
  assign n0   = (a0 > pk0) ? a0 : pk0;
  assign n1   = (a1 > pk1) ? a1 : pk1;
  assign last = (cnt == CNT_W'(BLK - 1));
  assign kmin = (k0 < k1) ? k0 : k1;

  asf_exp_calc #(.NB(W-1), .THR(2), .MAXE(MAXE), .EXP_W(EXP_W)) u_k0 (.mag(n0), .k(k0));
  asf_exp_calc #(.NB(W-1), .THR(2), .MAXE(MAXE), .EXP_W(EXP_W)) u_k1 (.mag(n1), .k(k1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pk0  <= '0;
      pk1  <= '0;
      cnt  <= '0;
      gain <= '0;
    end else if (in_valid) begin
      if (last) begin
        pk0  <= '0;
        pk1  <= '0;
        cnt  <= '0;
        gain <= kmin;
      end else begin
        pk0 <= n0;
        pk1 <= n1;
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_gain_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && last) |=> $stable(gain));
  p_peak_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && last) |=> (pk0 == '0 && pk1 == '0 && cnt == '0));
  p_gain_cap_r3: assert property (@(posedge clk) disable iff (rst)
    gain <= EXP_W'(MAXE));
endmodule

// File: rtl/asf_restore_align.sv
// Delays the exponent sum by the filter latency and forms per-output codes.
module asf_restore_align
  import asf_pkg::*;
#(
  parameter int LAT   = 4,
  parameter int EXP_W = 4,
  parameter int SW    = 5,
  parameter int MAXE  = 8,
  parameter int NOUT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EXP_W:0]    sum,
  input  logic [SW-1:0]     slide [NOUT],
  output logic [CODE_W-1:0] code  [NOUT]
);
  logic [EXP_W:0] dl [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) dl[i] <= '0;
    end else begin
      dl[0] <= sum;
      for (int i = 1; i < LAT; i++) dl[i] <= dl[i-1];
    end
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) code[g] <= '0;
      else     code[g] <= make_code(int'(dl[LAT-1]) - int'(slide[g]));
    end

    p_code_sign_r9: assert property (@(posedge clk) disable iff (rst)
      code[g][CODE_W-1] |-> (code[g][CODE_W-2:0] != '0));
  end

  p_sum_bound_r8: assert property (@(posedge clk) disable iff (rst)
    dl[LAT-1] <= (EXP_W+1)'(2*MAXE));
endmodule

// File: rtl/asf_ctrl.sv
module asf_ctrl
  import asf_pkg::*;
#(
  parameter int W     = 14,
  parameter int CW    = 16,
  parameter int SW    = 5,
  parameter int BLK   = 256,
  parameter int LAT   = 4,
  parameter int MAXE  = 8,
  parameter int EXP_W = $clog2(MAXE + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] adc0,
  input  logic signed [W-1:0] adc1,
  input  logic                coef_load,
  input  logic [CW-1:0]       coef_peak,
  input  logic [SW-1:0]       slide0,
  input  logic [SW-1:0]       slide1,
  output logic [EXP_W-1:0]    gain_exp,
  output logic [CODE_W-1:0]   restore0,
  output logic [CODE_W-1:0]   restore1
);
  logic [EXP_W-1:0]  kh, kh_next;
  logic [EXP_W:0]    sum;
  logic [SW-1:0]     slides [2];
  logic [CODE_W-1:0] codes  [2];

  asf_block_peak #(.W(W), .BLK(BLK), .MAXE(MAXE), .EXP_W(EXP_W)) u_peak (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .x0(adc0), .x1(adc1), .gain(gain_exp));

  asf_exp_calc #(.NB(CW), .THR(1), .MAXE(MAXE), .EXP_W(EXP_W)) u_kh (
    .mag({1'b0, coef_peak}), .k(kh_next));

  always_ff @(posedge clk) begin
    if (rst)            kh <= '0;
    else if (coef_load) kh <= kh_next;
  end

  assign sum       = {1'b0, gain_exp} + {1'b0, kh};
  assign slides[0] = slide0;
  assign slides[1] = slide1;

  asf_restore_align #(.LAT(LAT), .EXP_W(EXP_W), .SW(SW), .MAXE(MAXE), .NOUT(2)) u_align (
    .clk(clk), .rst(rst), .sum(sum), .slide(slides), .code(codes));

  assign restore0 = codes[0];
  assign restore1 = codes[1];

  p_coef_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !coef_load |=> $stable(kh));
  p_coef_cap_r7: assert property (@(posedge clk) disable iff (rst)
    kh <= EXP_W'(MAXE));
endmodule

// File: tb/tb_asf_ctrl.sv
module tb_asf_ctrl;
  localparam int W = 14, CW = 16, SW = 5, BLK = 256, LAT = 4, MAXE = 8;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic signed [W-1:0] adc0 = '0, adc1 = '0;
  logic coef_load = 0;
  logic [CW-1:0] coef_peak = '0;
  logic [SW-1:0] slide0 = '0, slide1 = '0;
  logic [3:0] gain_exp;
  logic [8:0] restore0, restore1;

  asf_ctrl dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_pk0 = 0, m_pk1 = 0, m_cnt = 0, m_gain = 0, m_kh = 0;
  int q[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int kexp(int p, int nb, int div);
    int k = 0;
    if (p >= (1 << nb) / div) return 0;
    while (k < MAXE && (p << k) < (1 << (nb - 1))) k++;
    return k;
  endfunction

  function automatic int code_of(int v);
    return (v > 0) ? 256 + v : -v;
  endfunction

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  function automatic int imax(int a, int b);
    return a > b ? a : b;
  endfunction

  // one clock: drive at negedge, update model, compare at next negedge
  task automatic cyc(bit v, int x0, int x1, bit ld, int cp, int s0, int s1);
    int old, e0, e1, p0, p1;
    in_valid = v; adc0 = W'(x0); adc1 = W'(x1);
    coef_load = ld; coef_peak = CW'(cp); slide0 = SW'(s0); slide1 = SW'(s1);
    q.push_back(m_gain + m_kh);
    old = q.pop_front();
    e0 = code_of(old - s0);
    e1 = code_of(old - s1);
    if (ld) m_kh = kexp(cp, CW, 2);
    if (v) begin
      p0 = imax(m_pk0, iabs(x0));
      p1 = imax(m_pk1, iabs(x1));
      if (m_cnt == BLK - 1) begin
        m_gain = kexp(p0, W - 1, 4) < kexp(p1, W - 1, 4) ? kexp(p0, W - 1, 4) : kexp(p1, W - 1, 4);
        m_pk0 = 0; m_pk1 = 0; m_cnt = 0;
      end else begin
        m_pk0 = p0; m_pk1 = p1; m_cnt++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("R6 gain_exp", gain_exp, m_gain);
    chk("R7 R8 R9 restore0", restore0, e0);
    chk("R7 R8 R9 restore1", restore1, e1);
  endtask

  // one block: peaks pa/pb exactly reached; optional invalid gaps with large values
  task automatic run_block(int pa, int pb, bit gaps, int s0, int s1, int ld_at, int cp);
    for (int i = 0; i < BLK; i++) begin
      int x0 = ((i * 13) % (pa + 1)) * ((i % 2) ? -1 : 1);
      int x1 = ((i * 7) % (pb + 1)) * ((i % 3) ? 1 : -1);
      if (i == 37) x0 = pa;
      if (i == 200) x1 = -pb;
      if (gaps && (i % 5 == 0)) cyc(0, 8000, -8000, 0, 0, s0, s1);
      cyc(1, x0, x1, i == ld_at, cp, s0, s1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gain_exp in reset", gain_exp, 0);
    chk("R1 restore0 in reset", restore0, 0);
    chk("R1 restore1 in reset", restore1, 0);
    rst = 0;
    for (int i = 0; i < LAT; i++) q.push_back(0);
    // R3 R4: peaks 100 -> 6, 300 -> 4; min 4
    run_block(100, 300, 0, 0, 3, 10, 'h4000);
    chk("R3 R4 gain small peaks", gain_exp, 4);
    // R2: 3000 >= quarter -> 0
    run_block(3000, 1500, 0, 2, 20, -1, 0);
    chk("R2 gain above quarter", gain_exp, 0);
    // R3: all zero -> cap 8; coef peak 3 -> cap 8
    run_block(0, 0, 0, 1, 0, 50, 3);
    chk("R3 gain zero peaks cap", gain_exp, 8);
    // R5: invalid cycles carry large values, ignored
    run_block(40, 40, 1, 5, 16, 100, 'h8000);
    chk("R5 gain ignores invalid", gain_exp, 7);
    // R5: most negative sample
    run_block(20, 8192, 0, 0, 31, -1, 0);
    chk("R5 gain most negative", gain_exp, 0);
    // R2 R3 boundary: 2047 -> 2, 2048 -> 0
    run_block(1024, 2047, 0, 0, 0, 0, 'h7fff);
    chk("R3 gain below quarter", gain_exp, 2);
    run_block(2048, 1, 0, 0, 0, 30, 0);
    chk("R2 gain at quarter", gain_exp, 0);
    repeat (LAT + 2) cyc(0, 0, 0, 0, 0, 4, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule